// File: doc/BRIEF.md
# Error Flag and Idle-Retention Control Register

This block is one 32-bit control word with a plain synchronous write port and a read port that always shows the current contents. Two bits of the word are sticky error indicators. One records uncorrectable cache-RAM ECC faults. The other records asynchronous faults from the external bus. Hardware sets each indicator with an event pulse. Software clears it only by writing a zero into its position. Each indicator drives its own active-low interrupt line.

The low three bits choose how many timer ticks the memory system must stay idle before the block raises a retention-entry request. The steps between thresholds are uneven, and code 000 turns the feature off. An internal counter adds one for each tick pulse seen while the idle input is high. The request is raised when the count reaches the selected threshold. It is held until idle falls, and that also restarts the count.

Top module: `errret_ctl`

## Requirements
- R1: Bit 30 (ECC fault flag) is set on the edge after `ecc_err_evt` is high, stays set with no further events, and is 0 after reset.
- R2: Bit 29 (bus fault flag) is set on the edge after `bus_err_evt` is high, stays set with no further events, and is 0 after reset.
- R3: A write with 0 in bit 30 or bit 29 clears that flag. A write with 1 there leaves the flag unchanged.
- R4: `ecc_irq_n` is low exactly when bit 30 is set, and `bus_irq_n` is low exactly when bit 29 is set.
- R5: When an event and a write-zero clear hit the same flag in the same cycle, the flag ends up set.
- R6: Bits [2:0] select the idle-tick threshold: 000 off, 001 = 2, 010 = 8, 011 = 32, 100 = 64, 101 = 128, 110 = 256, 111 = 512. The field resets to 000.
- R7: Bit 31 and bits [28:3] always read 0, and writing ones to them has no effect.
- R8: While `idle` is high, each `tick` pulse adds one to the count. `ret_req` rises on the edge that takes the threshold-th tick. Ticks seen while `idle` is low count for nothing.
- R9: A low `idle` drops `ret_req` on the next edge and returns the count to zero.
- R10: A write that changes bits [2:0] restarts the count and drops `ret_req`. Writing the same value does not restart the count. While the field is 000, `ret_req` stays low.
- R11: `rd_data` shows the current register value. A write becomes visible on the edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| ecc_err_evt | input | 1 | Uncorrectable cache-RAM ECC fault pulse |
| bus_err_evt | input | 1 | External bus asynchronous fault pulse |
| ecc_irq_n | output | 1 | Active-low interrupt for the ECC fault flag |
| bus_irq_n | output | 1 | Active-low interrupt for the bus fault flag |
| tick | input | 1 | One-cycle timer tick pulse |
| idle | input | 1 | Memory system idle indication |
| ret_req | output | 1 | Retention-entry request |

## Verification
The bench builds the block with its default parameters: the flags at bits 30 and 29, and a counter wide enough for the 512-tick threshold. With these values all eight retention codes can be swept to their exact crossing tick in a few thousand cycles. The flag logic is swept over every combination of prior flag state, written bit pattern and event pattern (64 cases). This reaches the set-versus-clear collision on both flags at once.

// File: rtl/errret_pkg.sv
package errret_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_THR = 512;
  localparam int unsigned CNT_W   = $clog2(MAX_THR) + 1;

  // Threshold per code: 2^1, 2^3, 2^5, then 2^(code+2) for codes 4..7; 0 = off
  function automatic logic [CNT_W-1:0] sel_to_thr(input logic [SEL_W-1:0] sel);
    int unsigned sh;
    logic [CNT_W-1:0] t;
    if (sel == '0) begin
      t = '0;
    end else begin
      if (sel < SEL_W'(3)) sh = 2 * int'(sel) - 1;
      else                 sh = int'(sel) + 2;
      t = CNT_W'(1) << sh;
    end
    return t;
  endfunction
endpackage

// File: rtl/errret_flag.sv
module errret_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_d  = flag_q;
    if (clr_req) flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;   // set wins over clear
    flag_en = set_evt | clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> $stable(flag_q));
endmodule

// File: rtl/errret_idle.sv
module errret_idle
  import errret_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             idle,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             req_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, thr;
  logic             req_d;
  logic             upd_en;

  always_comb begin
    thr     = sel_to_thr(sel);
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    req_d   = req_q;
    if (!idle || restart || (sel == '0)) begin
      cnt_d = '0;
      req_d = 1'b0;
    end else if (!req_q && tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc >= thr) req_d = 1'b1;
    end
    upd_en = (cnt_d != cnt_q) | (req_d != req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  a_r9_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> !req_q);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !req_q);
  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ($past(tick) && $past(idle)));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && idle && !restart && (sel != '0)) |=> req_q);
endmodule

// File: rtl/errret_ctl.sv
module errret_ctl
  import errret_pkg::*;
#(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned ECC_POS = 30,
  parameter int unsigned BUS_POS = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ecc_err_evt,
  input  logic             bus_err_evt,
  output logic             ecc_irq_n,
  output logic             bus_irq_n,
  input  logic             tick,
  input  logic             idle,
  output logic             ret_req
);
  localparam int unsigned NFLAG = 2;   // index 0 = bus, 1 = ECC
  localparam logic [REG_W-1:0] USED_MASK =
    (REG_W'(1) << ECC_POS) | (REG_W'(1) << BUS_POS) | REG_W'((1 << SEL_W) - 1);

  // reset: asserted asynchronously, released on clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // retention select field
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en, sel_chg;
  always_comb begin
    sel_d   = wr_data[SEL_W-1:0];
    sel_en  = wr_en;
    sel_chg = wr_en && (sel_d != sel_q);
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  // sticky fault flags
  logic [NFLAG-1:0] evt_vec, clr_vec, flag_q;
  assign evt_vec = {ecc_err_evt, bus_err_evt};

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    localparam int unsigned P = (gi == 0) ? BUS_POS : ECC_POS;
    assign clr_vec[gi] = wr_en & ~wr_data[P];
    errret_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .set_evt (evt_vec[gi]),
      .clr_req (clr_vec[gi]),
      .flag_q  (flag_q[gi])
    );
  end

  errret_idle u_idle (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .idle    (idle),
    .sel     (sel_q),
    .restart (sel_chg),
    .req_q   (ret_req)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[SEL_W-1:0]      = sel_q;
    rd_data[ECC_POS]        = flag_q[1];
    rd_data[BUS_POS]        = flag_q[0];
  end

  assign ecc_irq_n = ~flag_q[1];
  assign bus_irq_n = ~flag_q[0];

  logic unused_rsv_bits;
  assign unused_rsv_bits = ^(wr_data & ~USED_MASK);

  a_r11_sel_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> (rd_data[SEL_W-1:0] == $past(wr_data[SEL_W-1:0])));
  a_r10_off_no_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_data[SEL_W-1:0] == '0) |-> !ret_req);
  a_r1_ecc_event: assert property (@(posedge clk) disable iff (!rst_int_n)
    ecc_err_evt |=> (rd_data[ECC_POS] && !ecc_irq_n));
  a_r2_bus_event: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_err_evt |=> (rd_data[BUS_POS] && !bus_irq_n));
endmodule

// File: tb/sim_errret_ctl.sv
`timescale 1ns/1ps
module sim_errret_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ecc_err_evt, bus_err_evt;
  logic        ecc_irq_n, bus_irq_n;
  logic        tick, idle;
  logic        ret_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  errret_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ecc_err_evt(ecc_err_evt), .bus_err_evt(bus_err_evt),
    .ecc_irq_n(ecc_irq_n), .bus_irq_n(bus_irq_n),
    .tick(tick), .idle(idle), .ret_req(ret_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic int exp_thr(input int c);
    case (c)
      1: return 2;    2: return 8;    3: return 32;   4: return 64;
      5: return 128;  6: return 256;  7: return 512;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    ecc_err_evt = 1'b0; bus_err_evt = 1'b0; tick = 1'b0; idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check("R6 reset value", rd_data, 32'h0);
    check("R4 reset irq", {30'b0, ecc_irq_n, bus_irq_n}, 32'h3);
    check("R9 reset req", {31'b0, ret_req}, 32'h0);

    // flag sweep: prior state x written bits x events
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int e = 0; e < 4; e++) begin
          logic eccx, busx;
          logic [31:0] wd;
          wr(32'h0);
          if (s != 0) begin
            @(negedge clk); ecc_err_evt = s[1]; bus_err_evt = s[0];
            @(negedge clk); ecc_err_evt = 1'b0; bus_err_evt = 1'b0;
          end
          wd = '0; wd[30] = w[1]; wd[29] = w[0];
          @(negedge clk); wr_en = 1'b1; wr_data = wd;
          ecc_err_evt = e[1]; bus_err_evt = e[0];
          @(negedge clk); wr_en = 1'b0; wr_data = '0;
          ecc_err_evt = 1'b0; bus_err_evt = 1'b0;
          eccx = e[1] | (s[1] & w[1]);
          busx = e[0] | (s[0] & w[0]);
          check(e[1] ? (w[1] ? "R1" : "R5") : "R3 ecc", {31'b0, rd_data[30]}, {31'b0, eccx});
          check(e[0] ? (w[0] ? "R2" : "R5") : "R3 bus", {31'b0, rd_data[29]}, {31'b0, busx});
          check("R4", {30'b0, ecc_irq_n, bus_irq_n}, {30'b0, ~eccx, ~busx});
        end

    // reserved bits ignore writes; write visible after edge (R11)
    wr(32'h0);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    check("R11 before edge", rd_data, 32'h0);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R7 reserved", rd_data & 32'h9FFF_FFF8, 32'h0);
    check("R11 after edge", {29'b0, rd_data[2:0]}, 32'h7);

    // retention threshold sweep, all codes
    for (int c = 0; c < 8; c++) begin
      int t;
      t = exp_thr(c);
      wr(32'(c));
      @(negedge clk); idle = 1'b1;
      if (c == 0) begin
        ticks(600);
        check("R10 off", {31'b0, ret_req}, 32'h0);
      end else begin
        ticks(t - 1);
        check("R6 below thr", {31'b0, ret_req}, 32'h0);
        ticks(1);
        check("R8 at thr", {31'b0, ret_req}, 32'h1);
        ticks(3);
        check("R8 held", {31'b0, ret_req}, 32'h1);
        @(negedge clk); idle = 1'b0;
        @(negedge clk);
        check("R9 drop", {31'b0, ret_req}, 32'h0);
        idle = 1'b1;
        ticks(1);
        check("R9 restart", {31'b0, ret_req}, 32'h0);
      end
      @(negedge clk); idle = 1'b0;
    end

    // ticks without idle do not count (R8)
    wr(32'h1);
    ticks(5);
    @(negedge clk); idle = 1'b1;
    ticks(1);
    check("R8 no idle ticks", {31'b0, ret_req}, 32'h0);
    ticks(1);
    check("R8 count resumes", {31'b0, ret_req}, 32'h1);
    @(negedge clk); idle = 1'b0;

    // change of field restarts the count (R10)
    wr(32'h2);
    @(negedge clk); idle = 1'b1;
    ticks(5);
    wr(32'h1);
    ticks(1);
    check("R10 restart on change", {31'b0, ret_req}, 32'h0);
    ticks(1);
    check("R10 new thr", {31'b0, ret_req}, 32'h1);
    @(negedge clk); idle = 1'b0;

    // same value written: no restart (R10)
    wr(32'h2);
    @(negedge clk); idle = 1'b1;
    ticks(5);
    wr(32'h2);
    ticks(2);
    check("R10 same value", {31'b0, ret_req}, 32'h0);
    ticks(1);
    check("R10 same value crossing", {31'b0, ret_req}, 32'h1);

    // 000 drops pending request
    wr(32'h0);
    check("R10 zero drops", {31'b0, ret_req}, 32'h0);
    ticks(10);
    check("R10 zero stays", {31'b0, ret_req}, 32'h0);
    @(negedge clk); idle = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule